// File: doc/BRIEF.md
# Add/Subtract-and-Branch Unit

This unit adds or subtracts two 64-bit integer operands and, in the same step, decides whether a conditional branch is taken. The decision uses one flag of the result: zero, negative, strictly positive, signed overflow or unsigned carry/borrow. Each flag is evaluated at an operand width of 8, 16, 32 or 64 bits, chosen by a type code. An inversion bit in the opcode gives the complementary condition. The full-width sum or difference is always returned, whether or not the branch is taken.

A pipeline stage presents a request with a one-cycle strobe. One cycle later the unit returns four things: the result, the taken decision, the next instruction address and a fault flag. When the branch is taken, the next address is the current one plus four times the signed offset. Otherwise it is the current address. An unsupported type code or operation code raises the fault and suppresses the branch.

Top module: `addsub_branch_unit`

## Requirements
- R1: A request is captured on a clock edge where `in_valid` is 1, and `out_valid` is 1 in exactly the following cycle. When `in_valid` is 0, `out_valid` goes to 0 and `result`, `taken`, `next_ip` and `bad_param` keep their previous values.
- R2: After reset, `out_valid`, `result`, `taken`, `next_ip` and `bad_param` are all 0.
- R3: The selection code is `opcode[5:1]`, and bit 3 of that code picks add (1) or subtract (0). `result` is the full 64-bit `op_a + op_b` or `op_a - op_b`. It is produced for every request, taken or not, faulted or not.
- R4: `otype` 0, 1, 2 and 3 give operation widths of 8, 16, 32 and 64 bits; the masked result is the low W bits. Codes 0 (subtract) and 8 (add) test for a masked result of zero. Codes 1 and 9 test the sign bit at bit W-1. Codes 2 and 10 test for a clear sign bit together with a nonzero masked result.
- R5: Codes 3 and 11 test signed overflow at width W. Signed overflow means the exact signed result of the low W bits of the operands does not fit in W bits.
- R6: Codes 12 and 4 test the unsigned flag at width W. Code 12 is the carry out of the W-bit unsigned add. Code 4 is the borrow of the W-bit subtract, that is, masked `op_a` below masked `op_b`.
- R7: `opcode[0]` = 1 inverts the selected condition before it decides `taken`.
- R8: When taken, `next_ip` is `cur_ip + 4*offset`, where `offset` is a 24-bit two's-complement value and the sum wraps modulo 2^64. When not taken, `next_ip` equals `cur_ip`.
- R9: `bad_param` is 1 for `otype` 4 to 7 and for selection codes 5 to 7 and 13 to 31. While `bad_param` is 1, `taken` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 6 | [5:1] selection code, [0] invert |
| otype | input | 3 | Width code (0..3 valid) |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cur_ip | input | 64 | Current instruction address |
| offset | input | 24 | Signed branch offset in words |
| out_valid | output | 1 | Response valid, one cycle after request |
| result | output | 64 | Full-width sum or difference |
| taken | output | 1 | Branch decision |
| next_ip | output | 64 | Next instruction address |
| bad_param | output | 1 | Unsupported type or selection code |

## Verification
The arithmetic result and the branch decision with its target address come out of the same request in the same cycle. Every sweep vector therefore judges `result`, `taken` and `next_ip` together. A sweep covers every width, every valid code and both inversion settings. The operand pairs sit on the width's boundaries: zero, one, all-ones, the most negative value and its neighbours. Bits above the width are filled with garbage. Flags and targets are derived arithmetically: signed range checks on sign-extended operands, and a carry taken from a widened unsigned sum. Faulted requests must still return the correct sum while never taking the branch.

// File: rtl/addsub_branch_unit.sv
module addsub_branch_unit #(
  parameter int DW   = 64,
  parameter int IPW  = 64,
  parameter int OFFW = 24,
  parameter int TW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [5:0]      opcode,
  input  logic [TW-1:0]   otype,
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  input  logic [IPW-1:0]  cur_ip,
  input  logic [OFFW-1:0] offset,
  output logic            out_valid,
  output logic [DW-1:0]   result,
  output logic            taken,
  output logic [IPW-1:0]  next_ip,
  output logic            bad_param
);
  localparam int SHW = $clog2(DW) + 1;

  logic [4:0]     sel;
  logic           is_add;
  logic [SHW-1:0] wbits;
  logic [DW-1:0]  mask, sgn, sum, rm, am, ovf_vec;
  logic           f_zero, f_neg, f_pos, f_ovf, f_cy, cond, fault, take;
  logic [IPW-1:0] off_ext, target;

  assign sel    = opcode[5:1];
  assign is_add = sel[3];
  assign wbits  = SHW'(8) << otype[1:0];
  assign mask   = ~({DW{1'b1}} << wbits);
  assign sgn    = mask ^ (mask >> 1);

  assign sum = is_add ? op_a + op_b : op_a - op_b;
  assign rm  = sum & mask;
  assign am  = op_a & mask;

  assign f_zero  = (rm == '0);
  assign f_neg   = |(rm & sgn);
  assign f_pos   = !f_neg && !f_zero;
  assign ovf_vec = (is_add ? ~(op_a ^ op_b) : (op_a ^ op_b)) & (op_a ^ sum);
  assign f_ovf   = |(ovf_vec & sgn);
  assign f_cy    = is_add ? (rm < am) : (rm > am);

  always_comb begin
    case (sel[2:0])
      3'd0:    cond = f_zero;
      3'd1:    cond = f_neg;
      3'd2:    cond = f_pos;
      3'd3:    cond = f_ovf;
      3'd4:    cond = f_cy;
      default: cond = 1'b0;
    endcase
  end

  assign fault   = sel[4] || (sel[2:0] > 3'd4) || (otype > TW'(3));
  assign take    = !fault && (cond ^ opcode[0]);
  assign off_ext = {{(IPW-OFFW){offset[OFFW-1]}}, offset};
  assign target  = cur_ip + (off_ext << 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      taken     <= 1'b0;
      next_ip   <= '0;
      bad_param <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= sum;
        taken     <= take;
        next_ip   <= take ? target : cur_ip;
        bad_param <= fault;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(next_ip));
  a_r8_not_taken_ip: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !take |=> next_ip == $past(cur_ip));
  a_r9_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && bad_param |-> !taken);
  a_r3_result_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> result == ($past(opcode[4]) ? $past(op_a) + $past(op_b)
                                             : $past(op_a) - $past(op_b)));
endmodule

// File: tb/addsub_branch_unit_test.sv
`timescale 1ns/1ps
module addsub_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [2:0]  otype = '0;
  logic [63:0] op_a = '0, op_b = '0, cur_ip = '0;
  logic [23:0] offset = '0;
  logic        out_valid, taken, bad_param;
  logic [63:0] result, next_ip;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int nvec = 0;

  localparam logic [63:0] GARB = 64'hDEAD_BEEF_F00D_CAFE;

  addsub_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .otype(otype),
    .op_a(op_a), .op_b(op_b), .cur_ip(cur_ip), .offset(offset),
    .out_valid(out_valid), .result(result), .taken(taken), .next_ip(next_ip),
    .bad_param(bad_param));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] wmask(input logic [1:0] t);
    int w = 8 << t;
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] pat(input int k, input logic [1:0] t);
    logic [63:0] m = wmask(t);
    logic [63:0] smin = (m >> 1) + 64'd1;
    logic [63:0] v;
    case (k)
      0: v = 64'd0;
      1: v = 64'd1;
      2: v = 64'd2;
      3: v = m;
      4: v = m - 64'd1;
      5: v = smin;
      6: v = smin - 64'd1;
      default: v = smin + 64'd1;
    endcase
    return (v & m) | (GARB & ~m);
  endfunction

  function automatic logic signed [66:0] sx(input logic [63:0] v, input int w);
    logic signed [66:0] r = $signed({3'b000, v});
    if (((v >> (w - 1)) & 64'd1) != 64'd0) r = r - (67'sd1 <<< w);
    return r;
  endfunction

  task automatic run(input logic [5:0] opc, input logic [2:0] ty,
                     input logic [63:0] a, input logic [63:0] b);
    logic [4:0]  sel = opc[5:1];
    logic [1:0]  t2 = ty[1:0];
    int          w = 8 << t2;
    logic [63:0] m = wmask(t2);
    logic        isadd = sel[3];
    logic [63:0] r, rm, am, bm, ip, eip;
    logic [23:0] off;
    logic signed [66:0] s, lim;
    logic        zf, nf, pf, of, cf, cnd, flt, tk;
    string       tag;
    case (nvec % 4)
      0: off = 24'hFFFFFF;
      1: off = 24'd5;
      2: off = 24'h800000;
      default: off = 24'h7FFFFF;
    endcase
    ip = 64'h4000_0000_0000_0100 + 64'(nvec) * 64'd8;
    nvec++;
    r  = isadd ? a + b : a - b;
    rm = r & m; am = a & m; bm = b & m;
    zf = (rm == 64'd0);
    nf = ((rm >> (w - 1)) & 64'd1) != 64'd0;
    pf = !nf && !zf;
    s  = isadd ? sx(am, w) + sx(bm, w) : sx(am, w) - sx(bm, w);
    lim = 67'sd1 <<< (w - 1);
    of = (s >= lim) || (s < -lim);
    cf = isadd ? ((({1'b0, am} + {1'b0, bm}) >> w) != 65'd0) : (am < bm);
    flt = (ty > 3'd3) || sel[4] || (sel[2:0] > 3'd4);
    case (sel[2:0])
      3'd0: begin cnd = zf; tag = "R4 zero"; end
      3'd1: begin cnd = nf; tag = "R4 negative"; end
      3'd2: begin cnd = pf; tag = "R4 positive"; end
      3'd3: begin cnd = of; tag = "R5 overflow"; end
      3'd4: begin cnd = cf; tag = "R6 carry"; end
      default: begin cnd = 1'b0; tag = "R9 fault"; end
    endcase
    if (flt) tag = "R9 fault";
    else if (opc[0]) tag = {tag, " R7 inverted"};
    tk  = !flt && (cnd ^ opc[0]);
    eip = tk ? ip + ({{40{off[23]}}, off} << 2) : ip;

    opcode = opc; otype = ty; op_a = a; op_b = b; cur_ip = ip; offset = off;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", {63'd0, out_valid}, 64'd1);
    chk("R3 result", result, r);
    chk(tag, {63'd0, taken}, {63'd0, tk});
    chk("R8 next_ip", next_ip, eip);
    chk("R9 bad_param", {63'd0, bad_param}, {63'd0, flt});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    chk("R2 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R2 reset result", result, 64'd0);
    chk("R2 reset taken", {63'd0, taken}, 64'd0);
    chk("R2 reset next_ip", next_ip, 64'd0);
    chk("R2 reset bad_param", {63'd0, bad_param}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < 4; t++)
      for (int c = 0; c < 10; c++)
        for (int inv = 0; inv < 2; inv++)
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
              logic [4:0] sc = (c < 5) ? 5'(c) : 5'(c + 3);
              run({sc, 1'(inv)}, 3'(t), pat(i, 2'(t)), pat(j, 2'(t)));
            end

    foreach (GARB[k]) if (k < 6) begin
      logic [4:0] bad_codes [6] = '{5'd5, 5'd6, 5'd7, 5'd13, 5'd20, 5'd31};
      for (int inv = 0; inv < 2; inv++)
        run({bad_codes[k], 1'(inv)}, 3'd2, 64'h1234_5678_0000_0000, 64'h1234_5678_0000_0000);
    end
    for (int ty = 4; ty < 8; ty++)
      for (int inv = 0; inv < 2; inv++) begin
        run({5'd0, 1'(inv)}, 3'(ty), 64'd7, 64'd7);
        run({5'd8, 1'(inv)}, 3'(ty), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
      end

    run({5'd8, 1'b0}, 3'd3, 64'd10, 64'd20);
    held = result;
    in_valid = 1'b0;
    op_a = 64'd999; op_b = 64'd1; opcode = 6'd0; cur_ip = 64'h55;
    @(negedge clk);
    chk("R1 idle out_valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R1 idle holds result", result, held);
    chk("R1 idle holds next_ip", next_ip, 64'h4000_0000_0000_0100 + 64'(nvec - 1) * 64'd8);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule